// File: doc/BRIEF.md
# HDLC Receive Deframer

This block recovers bytes from a bit-serial HDLC payload stream. Each cycle with the bit-valid input high carries one line bit. The block hunts for the flag pattern and removes the zeros the transmitter inserted after runs of five ones. It gathers the remaining bits into bytes, first bit received in the least significant position, and checks each frame's check sequence with a 16-bit or 32-bit CRC. A configuration input chooses the CRC.

Every recovered byte leaves on `byte_o` with a one-cycle strobe. Flags between frames are presented the same way, as the byte 0x7E. Two status lines report how the most recent frame ended:

| `idle_end_o` | `fcs_ok_o` | Meaning |
|---|---|---|
| 1 | 1 | Good check sequence |
| 1 | 0 | Bad check sequence |
| 0 | 1 | Abort |
| 0 | 0 | Frame in progress |

Reception only runs while the receive-enable input is high.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While `rx_en_i` is low, no strobe is produced and both status outputs hold. Dropping `rx_en_i` also discards any frame in progress, and the block waits for a new flag before it accepts data again.
- R2: Within each recovered byte, the first data bit received appears on `byte_o[0]` and the eighth appears on `byte_o[7]`.
- R3: Each flag (line bits 0,1,1,1,1,1,1,0) produces one strobe with `byte_o` = 0x7E, and `idle_end_o` is high from that strobe on.
- R4: When a single flag separates two frames, exactly one strobe occurs with `idle_end_o` high between the last byte of the first frame and the first byte of the second.
- R5: A frame closed by a flag with a correct check sequence leaves `idle_end_o` = 1 and `fcs_ok_o` = 1, both updated together with the closing flag's strobe.
- R6: A frame closed by a flag with a wrong check sequence leaves `idle_end_o` = 1 and `fcs_ok_o` = 0.
- R7: Seven consecutive ones after a flag form an abort. An abort sets `idle_end_o` = 0 and `fcs_ok_o` = 1 with no strobe. The block then ignores bits until a flag, and that flag sets `idle_end_o` = 1 and `fcs_ok_o` = 0.
- R8: The first data byte strobe of a frame drives both status outputs low. They stay low until that frame ends.
- R9: With `crc_wide_i` low the check uses x^16+x^12+x^5+1; with it high it uses the 32-bit polynomial x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. In both cases the register is preset to all ones and processed least significant bit first. A frame is good when the register ends at 0xF0B8 (16-bit) or 0xDEBB20E3 (32-bit).
- R10: Inside a frame, a 0 that follows five consecutive 1s is discarded and does not count toward the byte.
- R11: A frame with fewer bytes than the check sequence (2 or 4) is reported as a bad check sequence.
- R12: A frame whose data bit count is not a multiple of 8 is reported as a bad check sequence.
- R13: After reset, `byte_stb_o`, `idle_end_o`, `fcs_ok_o` and `byte_o` are all 0 and the block is hunting for a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable |
| crc_wide_i | input | 1 | 0 selects the 16-bit check, 1 selects the 32-bit check |
| bit_vld_i | input | 1 | A line bit is present this cycle |
| bit_i | input | 1 | Serial line bit |
| byte_o | output | 8 | Recovered byte or flag |
| byte_stb_o | output | 1 | One-cycle strobe for `byte_o` |
| idle_end_o | output | 1 | Idle or frame-end status |
| fcs_ok_o | output | 1 | Check-sequence-valid / abort status |

## Verification
A wrong ones-run count makes recovered bytes differ from the sent payload within the same byte. It also shows as a missing or extra flag strobe a few bit times later. A damaged CRC register or fill counter stays hidden until the closing flag, where the status pair shows the wrong code on that flag's strobe. Because of this, every frame is compared byte for byte and its end status is read right after the closing flag. The sweep covers both CRC widths, a range of lengths, and payloads full of ones runs.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [31:0] POLY16_REFL = 32'h0000_8408;
  localparam logic [31:0] POLY32_REFL = 32'hEDB8_8320;
  localparam logic [31:0] MAGIC16     = 32'h0000_F0B8;
  localparam logic [31:0] MAGIC32     = 32'hDEBB_20E3;
  localparam logic [31:0] PRESET16    = 32'h0000_FFFF;
  localparam logic [31:0] PRESET32    = 32'hFFFF_FFFF;

  typedef enum logic {ST_HUNT, ST_LINK} rx_state_e;

  // classification of one line bit against the current ones run
  typedef struct packed {
    logic flag;
    logic abort;
    logic stuff;
    logic data;
  } line_evt_t;

  // eight LSB-first steps of the reflected CRC; the 16-bit form lives in bits 15:0
  function automatic logic [31:0] crc_step_byte(input logic [31:0] cur,
                                                input logic [7:0]  din,
                                                input logic        wide);
    logic [31:0] r;
    logic        fb;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ din[i];
      r  = r >> 1;
      if (fb) r = r ^ (wide ? POLY32_REFL : POLY16_REFL);
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_linecode.sv
module hdlc_rx_linecode
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned RUN_W = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      clear_i,
  input  logic      bit_i,
  output line_evt_t evt_o
);

  localparam logic [RUN_W-1:0] RUN_MAX   = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
  localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(6);

  logic [RUN_W-1:0] ones_q, ones_d;

  always_comb begin
    evt_o.flag  = !bit_i && (ones_q == RUN_FLAG);
    evt_o.stuff = !bit_i && (ones_q == RUN_STUFF);
    evt_o.abort =  bit_i && (ones_q == RUN_FLAG);
    evt_o.data  = !(evt_o.flag || evt_o.stuff || evt_o.abort);
  end

  always_comb begin
    ones_d = ones_q;
    if (clear_i) begin
      ones_d = '0;
    end else if (step_i) begin
      if (!bit_i)                 ones_d = '0;
      else if (ones_q != RUN_MAX) ones_d = ones_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else         ones_q <= ones_d;
  end

endmodule

// File: rtl/hdlc_rx_assemble.sv
module hdlc_rx_assemble #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [W-1:0]  data_o,
  output logic          done_o,
  output logic [CW-1:0] fill_o
);

  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // new bit enters at the top so the first bit ends at position 0
  assign data_o = {bit_i, sr_q[W-1:1]};
  assign done_o = shift_i && (cnt_q == LAST);
  assign fill_o = cnt_q;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d  = data_o;
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic       wide_i,
  input  logic [7:0] data_i,
  output logic       good_o
);

  logic [31:0] crc_q, crc_d;

  assign good_o = wide_i ? (crc_q == MAGIC32) : (crc_q == MAGIC16);

  always_comb begin
    crc_d = crc_q;
    if (init_i)     crc_d = wide_i ? PRESET32 : PRESET16;
    else if (upd_i) crc_d = crc_step_byte(crc_q, data_i, wide_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d;
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BCNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              crc_wide_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_stb_o,
  output logic              idle_end_o,
  output logic              fcs_ok_o
);

  localparam int unsigned       FILL_W    = $clog2(BYTE_W);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] FLAG_PAT  = BYTE_W'(8'h7E);
  localparam logic [BCNT_W-1:0] BCNT_MAX  = {BCNT_W{1'b1}};

  rx_state_e         state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              stb_q, stb_d, idle_q, idle_d, ok_q, ok_d;

  logic              step, in_link, flag_hit;
  line_evt_t         evt;
  logic              asm_shift, asm_clear, asm_done;
  logic [BYTE_W-1:0] asm_data;
  logic [FILL_W-1:0] asm_fill;
  logic              crc_good;
  logic [BCNT_W-1:0] fcs_len;

  assign step      = rx_en_i && bit_vld_i;
  assign in_link   = (state_q == ST_LINK);
  assign flag_hit  = step && evt.flag;
  assign asm_shift = step && in_link && evt.data;
  assign asm_clear = !rx_en_i || flag_hit;
  assign fcs_len   = crc_wide_i ? BCNT_W'(4) : BCNT_W'(2);

  hdlc_rx_linecode #(.RUN_W(3)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .clear_i (!rx_en_i),
    .bit_i   (bit_i),
    .evt_o   (evt)
  );

  hdlc_rx_assemble #(.W(BYTE_W), .CW(FILL_W)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (asm_clear),
    .shift_i (asm_shift),
    .bit_i   (bit_i),
    .data_o  (asm_data),
    .done_o  (asm_done),
    .fill_o  (asm_fill)
  );

  hdlc_rx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (flag_hit),
    .upd_i   (asm_done),
    .wide_i  (crc_wide_i),
    .data_i  (asm_data[7:0]),
    .good_o  (crc_good)
  );

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    byte_d  = byte_q;
    stb_d   = 1'b0;
    idle_d  = idle_q;
    ok_d    = ok_q;
    if (!rx_en_i) begin
      state_d = ST_HUNT;
    end else if (bit_vld_i) begin
      if (evt.flag) begin
        state_d = ST_LINK;
        stb_d   = 1'b1;
        byte_d  = FLAG_PAT;
        idle_d  = 1'b1;
        bcnt_d  = '0;
        if (!in_link)         ok_d = 1'b0;
        else if (bcnt_q != 0) ok_d = crc_good && (asm_fill == FILL_LAST) && (bcnt_q >= fcs_len);
      end else if (in_link) begin
        if (evt.abort) begin
          state_d = ST_HUNT;
          idle_d  = 1'b0;
          ok_d    = 1'b1;
        end else if (asm_done) begin
          stb_d  = 1'b1;
          byte_d = asm_data;
          if (bcnt_q != BCNT_MAX) bcnt_d = bcnt_q + BCNT_W'(1);
          if (bcnt_q == 0) begin
            idle_d = 1'b0;
            ok_d   = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      bcnt_q  <= '0;
      byte_q  <= '0;
      stb_q   <= 1'b0;
      idle_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      byte_q  <= byte_d;
      stb_q   <= stb_d;
      idle_q  <= idle_d;
      ok_q    <= ok_d;
    end
  end

  assign byte_o     = byte_q;
  assign byte_stb_o = stb_q;
  assign idle_end_o = idle_q;
  assign fcs_ok_o   = ok_q;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              bit_vld_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              byte_stb_o,
  input logic              idle_end_o,
  input logic              fcs_ok_o
);

  localparam logic [BYTE_W-1:0] FLAG_PAT = BYTE_W'(8'h7E);

  p_stb_needs_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |-> $past(rx_en_i && bit_vld_i));

  p_hold_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_en_i) |-> ($stable(idle_end_o) && $stable(fcs_ok_o)));

  p_idle_only_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_o && idle_end_o) |-> (byte_o == FLAG_PAT));

  p_end_on_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_end_o) |-> (byte_stb_o && byte_o == FLAG_PAT));

  p_abort_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fcs_ok_o) && !idle_end_o) |-> !byte_stb_o);

  p_data_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_o && !idle_end_o) |-> !fcs_ok_o);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .bit_vld_i  (bit_vld_i),
  .byte_o     (byte_o),
  .byte_stb_o (byte_stb_o),
  .idle_end_o (idle_end_o),
  .fcs_ok_o   (fcs_ok_o)
);

// File: tb/hdlc_rx_deframer_test.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en = 1'b0;
  logic       wide = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] byte_o;
  logic       byte_stb_o, idle_end_o, fcs_ok_o;

  always #5 clk = ~clk;

  hdlc_rx_deframer uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rx_en_i    (rx_en),
    .crc_wide_i (wide),
    .bit_vld_i  (bit_vld),
    .bit_i      (bit_in),
    .byte_o     (byte_o),
    .byte_stb_o (byte_stb_o),
    .idle_end_o (idle_end_o),
    .fcs_ok_o   (fcs_ok_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] tx [0:15];
  int         tx_n;
  int         ones_run;

  logic [7:0] cap_b [0:255];
  logic       cap_i [0:255];
  logic       cap_k [0:255];
  int         cap_n = 0;

  always @(negedge clk) begin
    if (byte_stb_o && cap_n < 256) begin
      cap_b[cap_n] = byte_o;
      cap_i[cap_n] = idle_end_o;
      cap_k[cap_n] = fcs_ok_o;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_raw(input logic b);
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic go_quiet();
    bit_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_raw(b[i]);
      ones_run = b[i] ? ones_run + 1 : 0;
      if (ones_run == 5) begin
        send_raw(1'b0);
        ones_run = 0;
      end
    end
  endtask

  function automatic logic [31:0] fcs_of(input int n, input bit w);
    logic [31:0] c;
    logic        fb;
    c = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ tx[k][i];
        c  = c >> 1;
        if (fb) c = c ^ (w ? 32'hEDB8_8320 : 32'h0000_8408);
      end
    return w ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic build(input int n, input int seed, input bit w);
    logic [31:0] f;
    for (int i = 0; i < n; i++)
      tx[i] = (i % 3 == 0) ? 8'hFF : (i % 3 == 1) ? 8'h7E : 8'((seed * 13 + i * 7) & 255);
    tx_n = n;
    f = fcs_of(n, w);
    for (int k = 0; k < (w ? 4 : 2); k++) begin
      tx[tx_n] = f[8*k +: 8];
      tx_n++;
    end
  endtask

  task automatic run_frame(input bit exp_ok, input int extra, input string tag);
    cap_n = 0;
    send_flag();
    for (int k = 0; k < tx_n; k++) send_byte(tx[k]);
    for (int k = 0; k < extra; k++) send_raw(1'b0);
    ones_run = 0;
    send_flag();
    go_quiet();
    if (extra == 0) begin
      check({tag, " R3 strobe count"}, cap_n, tx_n + 2);
      check({tag, " R3 opening flag"}, cap_b[0], 8'h7E);
      for (int k = 0; k < tx_n; k++)
        check({tag, " R2 R10 R9 byte"}, cap_b[k+1], tx[k]);
      if (tx_n > 0)
        check({tag, " R8 status low at start"}, {cap_i[1], cap_k[1]}, 2'b00);
    end
    check({tag, " R3 closing flag"}, cap_b[cap_n-1], 8'h7E);
    check({tag, " R5 R6 end status"}, {cap_i[cap_n-1], cap_k[cap_n-1]}, {1'b1, exp_ok});
    check({tag, " R5 R6 held status"}, {idle_end_o, fcs_ok_o}, {1'b1, exp_ok});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ones_run = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R13 reset outputs", {byte_stb_o, idle_end_o, fcs_ok_o, byte_o}, 11'h0);

    // R1: nothing while disabled
    cap_n = 0;
    send_flag(); send_byte(8'h3C); send_flag();
    go_quiet();
    check("R1 no strobe while off", cap_n, 0);
    check("R1 status held while off", {idle_end_o, fcs_ok_o}, 2'b00);

    rx_en = 1'b1;
    // R3: idle flags from hunt
    cap_n = 0;
    send_flag(); send_flag(); send_flag();
    go_quiet();
    check("R3 idle flag count", cap_n, 3);
    for (int k = 0; k < 3; k++)
      check("R3 idle flag value", {cap_b[k], cap_i[k]}, {8'h7E, 1'b1});

    // R9: sweep of good frames, both widths
    for (int w = 0; w < 2; w++) begin
      wide = w[0];
      for (int n = 0; n < 7; n++) begin
        build(n, n + 4 * w, w[0]);
        run_frame(1'b1, 0, "good");
      end
    end

    // R6: corrupted check sequence
    for (int w = 0; w < 2; w++) begin
      wide = w[0];
      build(3, 9, w[0]);
      tx[tx_n-1] = tx[tx_n-1] ^ 8'h01;
      run_frame(1'b0, 0, "badfcs R6");
    end

    // R11: shorter than the check sequence
    wide = 1'b0; tx[0] = 8'h55; tx_n = 1;
    run_frame(1'b0, 0, "short16 R11");
    wide = 1'b1; tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'h56; tx_n = 3;
    run_frame(1'b0, 0, "short32 R11");

    // R12: good bytes plus three stray bits
    wide = 1'b0;
    build(4, 2, 1'b0);
    run_frame(1'b0, 3, "unaligned R12");

    // R4: one shared flag between two frames
    cap_n = 0;
    send_flag();
    build(2, 5, 1'b0);
    for (int k = 0; k < tx_n; k++) send_byte(tx[k]);
    send_flag();
    build(2, 6, 1'b0);
    for (int k = 0; k < tx_n; k++) send_byte(tx[k]);
    send_flag();
    go_quiet();
    begin
      int idle_cnt;
      idle_cnt = 0;
      for (int k = 1; k < 9; k++) if (cap_i[k]) idle_cnt++;
      check("R4 one idle strobe between frames", idle_cnt, 1);
      check("R4 shared flag reports good", {cap_b[5], cap_i[5], cap_k[5]}, {8'h7E, 2'b11});
      check("R4 second frame good", {cap_i[10], cap_k[10]}, 2'b11);
    end

    // R7: abort, ignore, then flag
    cap_n = 0;
    send_flag();
    send_byte(8'h00); send_byte(8'h5A); send_byte(8'h00);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    go_quiet();
    check("R7 abort no strobe", cap_n, 4);
    check("R7 abort status", {idle_end_o, fcs_ok_o}, 2'b01);
    send_raw(1'b0); send_raw(1'b1); send_raw(1'b0); send_raw(1'b1);
    go_quiet();
    check("R7 ignored while hunting", cap_n, 4);
    send_flag();
    go_quiet();
    check("R7 flag after abort", {cap_n[7:0], idle_end_o, fcs_ok_o}, {8'd5, 2'b10});

    // R1: disable mid-frame drops to hunt
    cap_n = 0;
    send_flag(); send_byte(8'h11);
    rx_en = 1'b0;
    send_byte(8'h22);
    rx_en = 1'b1;
    send_byte(8'h33); send_byte(8'h44);
    go_quiet();
    check("R1 hunt after disable", cap_n, 2);
    check("R2 first byte value", cap_b[1], 8'h11);
    check("R8 status during frame", {idle_end_o, fcs_ok_o}, 2'b00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule